// File: doc/BRIEF.md
# Interrupt Coalescing Credit Controller

This block holds a bank of interrupt vectors. Each vector counts outstanding work as a signed credit count, keeps a mask bit and runs a coalescing countdown. Queue logic pulses `event_i` once per completed item, and each pulse adds one credit. The countdown moves down by one on each `tick_i` strobe. A vector raises its interrupt when three conditions hold together: credits are above zero, the vector is unmasked and the countdown has reached zero.

Software talks to each vector through a 32-byte register window on a simple synchronous read/write port. A single write to the credits register can return consumed credits, unmask the vector and restart the countdown. When a vector fires, the value held in its arm-mask register is copied into the mask. Software chooses that value to decide whether the vector masks itself after firing.

Top module: `irq_coal_bank`

## Requirements
- R1: After reset, every vector reads as masked (mask 1), with credits 0, countdown 0, reload value 0, arm-mask 0, and all `irq_o` bits low.
- R2: Each `event_i` pulse adds one to that vector's signed 16-bit credit count. The count saturates at +32767.
- R3: A credits write (offset 0x08) subtracts bits [14:0] of the write data from the count and ignores bit 15. The result saturates at -32768.
- R4: A credits read returns the signed count in bits [15:0] and zeros above. A credits write with bit 17 set and bit 16 clear leaves the count unchanged, whatever value bits [15:0] hold.
- R5: A credits write with bit 16 set clears the mask bit.
- R6: A credits write with bit 17 set loads the countdown from the reload register (offset 0x00, bits [15:0]). A write with both bits 16 and 17 set also unmasks the vector and returns credits.
- R7: On each `tick_i` the countdown drops by one while it is nonzero, and it holds at zero. Reading offset 0x10 returns the remaining count.
- R8: `irq_o[v]` is high in the cycle after a cycle in which that vector had credits > 0, mask 0 and countdown 0. With a reload value of 0, an unmasked vector holding credits therefore fires at once.
- R9: When a vector fires, its arm-mask (offset 0x0C, bit 0) is copied into the mask in the same clock edge. Priority on the mask is: mask write first, then credits unmask, then the copy on firing.
- R10: A write to offset 0x04 sets the mask to bit 0 of the write data, where 0 is unmasked and 1 is masked. Reading that offset returns the mask in bit 0.
- R11: Address bits [4:0] select the register and the bits above them select the vector, so windows are 32 bytes apart. Read data appears on `reg_rdata_o` one cycle after `reg_re_i` and reflects the state before any same-cycle write. Unmapped offsets read 0 and ignore writes.
- R12: Vectors are independent. Events, ticks and writes to one vector leave every other vector's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | ADDR_W | Byte address: vector in [ADDR_W-1:5], register in [4:0] |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_re_i | input | 1 | Register read strobe |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| event_i | input | NUM_VEC | Per-vector credit event pulses |
| tick_i | input | 1 | Countdown tick enable |
| irq_o | output | NUM_VEC | Per-vector interrupt pulses |

## Verification
The case hardest to reach from the ports is credit saturation at both ends. Reaching +32767 takes tens of thousands of event pulses, and reaching -32768 then takes repeated large returns on a vector that stays masked the whole time. The stimulus does this with a long directed run of events into one masked vector, followed by maximal-count credit writes, one of which carries bit 15 to show that bit is ignored. Constrained random traffic then mixes events, ticks and all register writes across vectors, including collisions between firing and mask writes, and a bench model follows every one.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
  localparam logic [4:0] OFS_INIT    = 5'h00;
  localparam logic [4:0] OFS_MASK    = 5'h04;
  localparam logic [4:0] OFS_CRED    = 5'h08;
  localparam logic [4:0] OFS_MASSERT = 5'h0C;
  localparam logic [4:0] OFS_REMAIN  = 5'h10;

  localparam int unsigned WIN_BITS    = 5;
  localparam int unsigned RET_W       = 15;
  localparam int unsigned UNMASK_BIT  = 16;
  localparam int unsigned RESTART_BIT = 17;

  typedef struct packed {
    logic init_we;
    logic mask_we;
    logic cred_we;
    logic massert_we;
  } vec_wr_t;
endpackage

// File: rtl/irq_credit_ctr.sv
module irq_credit_ctr #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned RET_W = 15
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ev_i,
  input  logic                    ret_i,
  input  logic [RET_W-1:0]        ret_cnt_i,
  output logic signed [CNT_W-1:0] cnt_o
);
  localparam int unsigned SUM_W = CNT_W + 2;
  localparam logic signed [SUM_W-1:0] MAX_V = {{(SUM_W-CNT_W+1){1'b0}}, {(CNT_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] MIN_V = {{(SUM_W-CNT_W+1){1'b1}}, {(CNT_W-1){1'b0}}};
  localparam logic signed [CNT_W-1:0] CNT_MAX = MAX_V[CNT_W-1:0];
  localparam logic signed [CNT_W-1:0] CNT_MIN = MIN_V[CNT_W-1:0];

  logic signed [CNT_W-1:0] cnt_q, cnt_d;
  logic signed [SUM_W-1:0] sum;
  logic [RET_W-1:0]        ret_eff;

  always_comb begin
    ret_eff = ret_i ? ret_cnt_i : '0;
    sum = SUM_W'(cnt_q)
        + $signed({{(SUM_W-1){1'b0}}, ev_i})
        - $signed({{(SUM_W-RET_W){1'b0}}, ret_eff});
    if (sum > MAX_V)      cnt_d = CNT_MAX;
    else if (sum < MIN_V) cnt_d = CNT_MIN;
    else                  cnt_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2
  ev_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i && !ret_i && cnt_q != CNT_MAX |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  // R2
  max_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i && !ret_i && cnt_q == CNT_MAX |=> cnt_q == CNT_MAX);
  // R3
  min_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_i && ret_i && cnt_q == CNT_MIN |=> cnt_q == CNT_MIN);
endmodule

// File: rtl/irq_coal_timer.sv
module irq_coal_timer #(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMR_W-1:0] init_i,
  input  logic             load_i,
  input  logic             tick_i,
  output logic [TMR_W-1:0] remain_o,
  output logic             zero_o
);
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   tmr_q <= '0;
    else if (load_i)               tmr_q <= init_i;
    else if (tick_i && tmr_q != 0) tmr_q <= tmr_q - 1'b1;
  end

  assign remain_o = tmr_q;
  assign zero_o   = (tmr_q == '0);

  // R7
  tick_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !load_i && tmr_q != 0 |=> tmr_q == $past(tmr_q) - 1'b1);
  // R7
  zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && tmr_q == 0 |=> tmr_q == 0);
  // R6
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> tmr_q == $past(init_i));
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
  import irq_coal_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TMR_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  vec_wr_t                 wr_i,
  input  logic [RESTART_BIT:0]    wdata_i,
  input  logic                    ev_i,
  input  logic                    tick_i,
  output logic                    irq_o,
  output logic signed [CNT_W-1:0] cred_o,
  output logic                    mask_o,
  output logic                    massert_o,
  output logic [TMR_W-1:0]        init_o,
  output logic [TMR_W-1:0]        remain_o
);
  logic [TMR_W-1:0] init_q;
  logic             mask_q, massert_q, irq_q;
  logic             restart, unmask, ret, fire, tmr_zero;
  logic signed [CNT_W-1:0] cred;

  assign restart = wr_i.cred_we && wdata_i[RESTART_BIT];
  assign unmask  = wr_i.cred_we && wdata_i[UNMASK_BIT];
  // restart-only write keeps the count
  assign ret     = wr_i.cred_we && !(wdata_i[RESTART_BIT] && !wdata_i[UNMASK_BIT]);

  irq_credit_ctr #(.CNT_W(CNT_W), .RET_W(RET_W)) u_cred (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev_i),
    .ret_i     (ret),
    .ret_cnt_i (wdata_i[RET_W-1:0]),
    .cnt_o     (cred)
  );

  irq_coal_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .init_i   (init_q),
    .load_i   (restart),
    .tick_i   (tick_i),
    .remain_o (remain_o),
    .zero_o   (tmr_zero)
  );

  assign fire = !cred[CNT_W-1] && (cred != '0) && !mask_q && tmr_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q    <= '0;
      mask_q    <= 1'b1;
      massert_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= fire;
      if (wr_i.init_we)    init_q    <= wdata_i[TMR_W-1:0];
      if (wr_i.massert_we) massert_q <= wdata_i[0];
      if (wr_i.mask_we)    mask_q    <= wdata_i[0];
      else if (unmask)     mask_q    <= 1'b0;
      else if (fire)       mask_q    <= massert_q;
    end
  end

  assign irq_o     = irq_q;
  assign cred_o    = cred;
  assign mask_o    = mask_q;
  assign massert_o = massert_q;
  assign init_o    = init_q;

  // R8
  fire_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> irq_o);
  // R8
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q |=> !irq_o);
  // R9
  arm_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !wr_i.mask_we && !unmask |=> mask_q == $past(massert_q));
  // R5
  unmask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmask && !wr_i.mask_we |=> !mask_q);
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_coal_pkg::*;
#(
  parameter int unsigned NUM_VEC = 4,
  parameter int unsigned ADDR_W  = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     we_i,
  output vec_wr_t [NUM_VEC-1:0]    wr_o,
  output logic [ADDR_W-WIN_BITS-1:0] vec_o,
  output logic [WIN_BITS-1:0]      ofs_o,
  output logic                     hit_o
);
  localparam int unsigned VEC_W = ADDR_W - WIN_BITS;

  logic map_hit;

  assign vec_o   = addr_i[ADDR_W-1:WIN_BITS];
  assign ofs_o   = addr_i[WIN_BITS-1:0];
  assign map_hit = (ofs_o == OFS_INIT) || (ofs_o == OFS_MASK) || (ofs_o == OFS_CRED)
                || (ofs_o == OFS_MASSERT) || (ofs_o == OFS_REMAIN);
  assign hit_o   = map_hit && (32'(vec_o) < NUM_VEC);

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_dec
    logic sel;
    assign sel = we_i && hit_o && (vec_o == VEC_W'(v));
    assign wr_o[v].init_we    = sel && (ofs_o == OFS_INIT);
    assign wr_o[v].mask_we    = sel && (ofs_o == OFS_MASK);
    assign wr_o[v].cred_we    = sel && (ofs_o == OFS_CRED);
    assign wr_o[v].massert_we = sel && (ofs_o == OFS_MASSERT);
  end

  // R11
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !map_hit |-> wr_o == '0);
  // R12
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_o));
endmodule

// File: rtl/irq_coal_bank.sv
module irq_coal_bank
  import irq_coal_pkg::*;
#(
  parameter int unsigned NUM_VEC = 4,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned TMR_W   = 16,
  parameter int unsigned ADDR_W  = $clog2(NUM_VEC) + 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_we_i,
  input  logic [31:0]         reg_wdata_i,
  input  logic                reg_re_i,
  output logic [31:0]         reg_rdata_o,
  input  logic [NUM_VEC-1:0]  event_i,
  input  logic                tick_i,
  output logic [NUM_VEC-1:0]  irq_o
);
  localparam int unsigned VEC_W = ADDR_W - WIN_BITS;

  vec_wr_t [NUM_VEC-1:0]   wr;
  logic [VEC_W-1:0]        vec;
  logic [WIN_BITS-1:0]     ofs;
  logic                    hit;
  logic [31:0]             rd_d, rdata_q;

  logic signed [CNT_W-1:0] cred   [NUM_VEC];
  logic                    mask   [NUM_VEC];
  logic                    massert[NUM_VEC];
  logic [TMR_W-1:0]        init   [NUM_VEC];
  logic [TMR_W-1:0]        remain [NUM_VEC];

  irq_reg_decode #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (reg_addr_i),
    .we_i   (reg_we_i),
    .wr_o   (wr),
    .vec_o  (vec),
    .ofs_o  (ofs),
    .hit_o  (hit)
  );

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    irq_vec_unit #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_vec (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr[v]),
      .wdata_i   (reg_wdata_i[RESTART_BIT:0]),
      .ev_i      (event_i[v]),
      .tick_i    (tick_i),
      .irq_o     (irq_o[v]),
      .cred_o    (cred[v]),
      .mask_o    (mask[v]),
      .massert_o (massert[v]),
      .init_o    (init[v]),
      .remain_o  (remain[v])
    );
  end

  always_comb begin
    rd_d = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (hit && vec == VEC_W'(v)) begin
        unique case (ofs)
          OFS_INIT:    rd_d = 32'(init[v]);
          OFS_MASK:    rd_d = {31'b0, mask[v]};
          OFS_CRED:    rd_d = 32'(unsigned'(cred[v]));
          OFS_MASSERT: rd_d = {31'b0, massert[v]};
          OFS_REMAIN:  rd_d = 32'(remain[v]);
          default:     rd_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_re_i) rdata_q <= rd_d;
  end

  assign reg_rdata_o = rdata_q;

  // R11
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_re_i |=> $stable(reg_rdata_o));
endmodule

// File: tb/irq_coal_bank_test.sv
`timescale 1ns/1ps
module irq_coal_bank_test;
  localparam int NV = 4;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0, re = 1'b0, tick = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NV-1:0] ev = '0;
  logic [NV-1:0] irq;

  int checks = 0, fails = 0;

  int m_cred[NV], m_tmr[NV], m_init[NV];
  bit m_mask[NV], m_arm[NV];

  always #2 clk = ~clk;

  irq_coal_bank #(.NUM_VEC(NV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_re_i(re), .reg_rdata_o(rdata),
    .event_i(ev), .tick_i(tick), .irq_o(irq)
  );

  function automatic int sat(int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic bit m_fire(int v);
    return m_cred[v] > 0 && !m_mask[v] && m_tmr[v] == 0;
  endfunction

  function automatic logic [31:0] m_read(logic [AW-1:0] a);
    int v = int'(a[AW-1:5]);
    case (a[4:0])
      5'h00: return 32'(m_init[v]);
      5'h04: return {31'b0, m_mask[v]};
      5'h08: return {16'b0, 16'(m_cred[v])};
      5'h0C: return {31'b0, m_arm[v]};
      5'h10: return 32'(m_tmr[v]);
      default: return 32'b0;
    endcase
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit w, bit r, logic [AW-1:0] a, logic [31:0] d,
                      logic [NV-1:0] e, bit t, string tag);
    bit            f[NV];
    logic [31:0]   exp_rd;
    int            v;
    @(negedge clk);
    we = w; re = r; addr = a; wdata = d; ev = e; tick = t;
    exp_rd = m_read(a);
    for (int i = 0; i < NV; i++) f[i] = m_fire(i);
    v = int'(a[AW-1:5]);
    for (int i = 0; i < NV; i++) begin
      bit cw = w && i == v && a[4:0] == 5'h08;
      int nc = m_cred[i] + int'(e[i]);
      if (cw && !(d[17] && !d[16])) nc -= int'(d[14:0]);
      if (w && i == v && a[4:0] == 5'h04) m_mask[i] = d[0];
      else if (cw && d[16])               m_mask[i] = 1'b0;
      else if (f[i])                      m_mask[i] = m_arm[i];
      if (cw && d[17])               m_tmr[i] = m_init[i];
      else if (t && m_tmr[i] > 0)    m_tmr[i] = m_tmr[i] - 1;
      m_cred[i] = sat(nc);
    end
    if (w && a[4:0] == 5'h00) m_init[v] = int'(d[15:0]);
    if (w && a[4:0] == 5'h0C) m_arm[v]  = d[0];
    @(posedge clk);
    #1;
    for (int i = 0; i < NV; i++) chk({tag, " R8 irq"}, 32'(irq[i]), 32'(f[i]));
    if (r) chk({tag, " rdata"}, rdata, exp_rd);
    we = 1'b0; re = 1'b0; ev = '0; tick = 1'b0;
  endtask

  function automatic logic [AW-1:0] ad(int v, int o);
    return AW'(v * 32 + o);
  endfunction

  task automatic rd(int v, int o, string tag);
    step(0, 1, ad(v, o), 0, '0, 0, tag);
  endtask

  task automatic wr(int v, int o, logic [31:0] d, string tag);
    step(1, 0, ad(v, o), d, '0, 0, tag);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) begin
      m_cred[i] = 0; m_tmr[i] = 0; m_init[i] = 0; m_mask[i] = 1; m_arm[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int o = 0; o <= 16; o += 4) rd(0, o, "R1");
    rd(3, 8, "R1");

    // R6 reload, R9 arm-mask, R2 events, rearm write
    wr(1, 0, 3, "R6");
    wr(1, 12, 1, "R9");
    step(0, 0, '0, 0, 4'b0010, 0, "R2");
    step(0, 0, '0, 0, 4'b0010, 0, "R2");
    rd(1, 8, "R2");
    wr(1, 8, 32'h30000, "R6");
    rd(1, 16, "R6");
    rd(1, 4, "R5");
    for (int k = 0; k < 3; k++) step(0, 1, ad(1, 16), 0, '0, 1, "R7");
    step(0, 0, '0, 0, '0, 1, "R7");
    rd(1, 16, "R7");
    rd(1, 4, "R9");
    rd(1, 8, "R4");

    // R10 mask write, R8 immediate fire with zero reload
    step(0, 0, '0, 0, 4'b1000, 0, "R2");
    wr(3, 4, 0, "R10");
    rd(3, 4, "R10");
    rd(3, 4, "R8");
    wr(3, 4, 1, "R10");
    rd(3, 4, "R10");

    // R2 saturation high on masked vector 2
    for (int k = 0; k < 32800; k++) step(0, 0, '0, 0, 4'b0100, 0, "R2");
    rd(2, 8, "R2");
    // R3 bit 15 ignored, saturation low
    wr(2, 8, 32'h0000FFFF, "R3");
    rd(2, 8, "R3");
    wr(2, 8, 32'h00008001, "R3");
    rd(2, 8, "R3");
    wr(2, 8, 32'h00007FFF, "R3");
    wr(2, 8, 32'h00007FFF, "R3");
    rd(2, 8, "R3");
    // R4 restart-only write-back
    wr(2, 8, 32'h00028000, "R4");
    rd(2, 8, "R4");

    // R11 unmapped offset
    wr(0, 20, 32'hFFFFFFFF, "R11");
    rd(0, 20, "R11");
    rd(0, 0, "R11");
    rd(0, 4, "R11");

    // R12 random mix across vectors
    for (int k = 0; k < 6000; k++) begin
      int       v  = int'($urandom_range(0, NV - 1));
      int       sel = int'($urandom_range(0, 5));
      int       o  = (sel == 5) ? 20 : sel * 4;
      bit       w  = ($urandom_range(0, 3) == 0);
      bit       r  = ($urandom_range(0, 1) == 1);
      logic [31:0] d;
      logic [NV-1:0] e = '0;
      for (int i = 0; i < NV; i++) e[i] = ($urandom_range(0, 9) < 3);
      case (o)
        0:  d = 32'($urandom_range(0, 5));
        8:  d = {14'b0, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 7) == 0),
                 15'($urandom_range(0, 3))};
        default: d = $urandom;
      endcase
      step(w, r, ad(v, o), d, e, $urandom_range(0, 1) == 1, "R12");
    end
    for (int v = 0; v < NV; v++) for (int o = 0; o <= 16; o += 4) rd(v, o, "R12");

    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule